// File: doc/BRIEF.md
# Rail Fault and Power-Good Supervisor

This block watches the digital undervoltage flags of four switched supply rails, two undervoltage-lockout flags and a die over-temperature flag. It drives one output-kill line that forces every rail off, and a power-good line that goes high only when every rail that is meant to be on is valid. Comparators and references sit outside. The block takes their one-bit results and the current sleep state.

An undervoltage flag has to stay set for a programmable number of consecutive clock cycles before it counts as a short. The fault is then latched. The first rail to trip is recorded. The latch holds until the standby supply is recycled, which the block sees as its active-low reset. The two memory rails are switched off on purpose in the deepest sleep state, so their flags are masked there. Lockout and over-temperature kill the outputs only while they last, and they suspend the trip counting so that rails falling during a shutdown cannot latch a fault.

Top module: `rail_supervisor`

## Requirements
- R1: While reset (`rstStbyN` low) is applied, `killOut` and `faultLatched` are 0, `faultRail` is 0 and `pwrGood` is 0.
- R2: A monitored rail flag that is high on `TRIP_CYCLES` consecutive rising clock edges sets `faultLatched` at the last of those edges, and `killOut` follows at once.
- R3: A flag that stays high for fewer than `TRIP_CYCLES` edges does not latch a fault, and any low cycle restarts its count from zero.
- R4: Once set, `faultLatched` and `killOut` stay 1 whatever the rails, lockout flags or power state do, until `rstStbyN` is driven low.
- R5: `faultRail` holds the index (0 to 3) of the rail whose count completed first. When several rails complete on the same edge the lowest index wins, and later trips leave it unchanged.
- R6: When `pwrState` is 2'b10 (deepest sleep; 2'b00 and 2'b01 are the awake and suspend states), the flags of rails 2 and 3 neither count toward a trip nor pull `pwrGood` low. Their count starts from zero when that state is left.
- R7: While `uvloStby` or `uvlo12` is 1, `killOut` is 1 in the same cycle. It returns to 0 when both flags clear, with no fault latched.
- R8: While `overTemp` is 1, `killOut` is 1. It returns to 0 when the flag clears, with no fault latched.
- R9: `pwrGood` is 0 in any cycle in which `killOut` is 1 or a monitored rail flag is 1.
- R10: `pwrGood` becomes 1 only after `PG_DELAY` consecutive edges on which the outputs were valid. Any invalid cycle restarts this wait.
- R11: While a lockout or over-temperature shutdown is active, trip counting is suspended and cleared. A rail still low after the shutdown ends needs a full `TRIP_CYCLES` to trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rstStbyN | input | 1 | Active-low standby power-on reset; the only way to clear a latched fault |
| railLow | input | 4 | Per-rail undervoltage flags; bits 2 and 3 are the memory rails |
| uvloStby | input | 1 | Standby supply under lockout threshold |
| uvlo12 | input | 1 | 12 V supply under lockout threshold |
| overTemp | input | 1 | Die over-temperature flag |
| pwrState | input | 2 | 00 awake, 01 suspend, 10 deepest sleep, 11 treated as awake |
| killOut | output | 1 | Forces all rails off |
| pwrGood | output | 1 | High when all enabled rails are valid |
| faultLatched | output | 1 | Latched short-circuit fault |
| faultRail | output | 2 | Index of the rail that caused the latched fault |

## Verification
The bench builds the supervisor with `TRIP_CYCLES` = 8 and `PG_DELAY` = 4. The default values correspond to microsecond windows of many thousands of cycles. The short values bring the exact trip edge, the one-cycle-short dip, simultaneous and staggered trips, and the power-good restart within a few cycles of each other, so each boundary can be sampled on its exact edge. They also make it cheap to hold a lockout long enough to prove that counting is suspended, and to switch the sleep state while a memory rail is still low.

// File: rtl/rail_sup_pkg.sv
package rail_sup_pkg;

  localparam int unsigned SUP_RAILS = 4;
  localparam int unsigned SUP_IDX_W = $clog2(SUP_RAILS);

  typedef enum logic [1:0] {
    PS_AWAKE   = 2'b00,
    PS_SUSPEND = 2'b01,
    PS_DEEP    = 2'b10,
    PS_SPARE   = 2'b11
  } pwr_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic [SUP_RAILS-1:0] cntRun; // per-rail: monitored rail seen low this cycle
    logic                 pgRun;  // outputs valid this cycle
  } sup_strobe_t;

endpackage

// File: rtl/rail_sup_ctrl.sv
module rail_sup_ctrl
  import rail_sup_pkg::*;
#(
  parameter logic [SUP_RAILS-1:0] MEM_MASK = 4'b1100
) (
  input  logic [SUP_RAILS-1:0] railLow,
  input  logic                 uvloStby,
  input  logic                 uvlo12,
  input  logic                 overTemp,
  input  logic [1:0]           pwrState,
  input  logic                 faultLatched,
  input  logic                 pgDone,
  output sup_strobe_t          stb,
  output logic                 killOut,
  output logic                 pwrGood
);

  logic                 tempOff;
  logic                 monActive;
  logic [SUP_RAILS-1:0] railEn;
  logic [SUP_RAILS-1:0] seenLow;

  always_comb begin
    tempOff   = uvloStby | uvlo12 | overTemp;
    killOut   = tempOff | faultLatched;
    monActive = ~tempOff & ~faultLatched;
    railEn    = (pwr_state_e'(pwrState) == PS_DEEP) ? ~MEM_MASK : '1;
    seenLow   = railLow & railEn;

    stb.cntRun = monActive ? seenLow : '0;
    stb.pgRun  = ~killOut & ~(|seenLow);
    pwrGood    = stb.pgRun & pgDone;
  end

endmodule

// File: rtl/rail_sup_datapath.sv
module rail_sup_datapath
  import rail_sup_pkg::*;
#(
  parameter int unsigned TRIP_CYCLES = 18750,
  parameter int unsigned PG_DELAY    = 1024
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sup_strobe_t          stb,
  output logic                 faultLatched,
  output logic [SUP_IDX_W-1:0] faultRail,
  output logic                 pgDone
);

  localparam int unsigned CNT_W = $clog2(TRIP_CYCLES + 1);
  localparam int unsigned PG_W  = $clog2(PG_DELAY + 1);
  localparam logic [CNT_W-1:0] TRIP_LAST = CNT_W'(TRIP_CYCLES - 1);
  localparam logic [PG_W-1:0]  PG_FULL   = PG_W'(PG_DELAY);

  logic [SUP_RAILS-1:0] tripVec;
  logic [SUP_IDX_W-1:0] firstIdx;
  logic [PG_W-1:0]      pgCnt;

  // one deglitch counter per rail
  for (genvar gi = 0; gi < SUP_RAILS; gi++) begin : g_rail
    logic [CNT_W-1:0] lowCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    lowCnt <= '0;
      else if (!stb.cntRun[gi])     lowCnt <= '0;
      else if (lowCnt != TRIP_LAST) lowCnt <= lowCnt + 1'b1;
    end

    assign tripVec[gi] = stb.cntRun[gi] && (lowCnt == TRIP_LAST);
  end

  // lowest index wins among rails completing on the same edge
  always_comb begin
    firstIdx = '0;
    for (int k = SUP_RAILS - 1; k >= 0; k--) begin
      if (tripVec[k]) firstIdx = SUP_IDX_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLatched <= 1'b0;
      faultRail    <= '0;
    end else if (!faultLatched && (|tripVec)) begin
      faultLatched <= 1'b1;
      faultRail    <= firstIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pgCnt <= '0;
    else if (!stb.pgRun)      pgCnt <= '0;
    else if (pgCnt != PG_FULL) pgCnt <= pgCnt + 1'b1;
  end

  assign pgDone = (pgCnt == PG_FULL);

endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
  import rail_sup_pkg::*;
#(
  parameter int unsigned          TRIP_CYCLES = 18750,
  parameter int unsigned          PG_DELAY    = 1024,
  parameter logic [SUP_RAILS-1:0] MEM_MASK    = 4'b1100
) (
  input  logic                 clk,
  input  logic                 rstStbyN,
  input  logic [SUP_RAILS-1:0] railLow,
  input  logic                 uvloStby,
  input  logic                 uvlo12,
  input  logic                 overTemp,
  input  logic [1:0]           pwrState,
  output logic                 killOut,
  output logic                 pwrGood,
  output logic                 faultLatched,
  output logic [SUP_IDX_W-1:0] faultRail
);

  sup_strobe_t stb;
  logic        pgDone;

  rail_sup_ctrl #(.MEM_MASK(MEM_MASK)) u_ctrl (
    .railLow      (railLow),
    .uvloStby     (uvloStby),
    .uvlo12       (uvlo12),
    .overTemp     (overTemp),
    .pwrState     (pwrState),
    .faultLatched (faultLatched),
    .pgDone       (pgDone),
    .stb          (stb),
    .killOut      (killOut),
    .pwrGood      (pwrGood)
  );

  rail_sup_datapath #(.TRIP_CYCLES(TRIP_CYCLES), .PG_DELAY(PG_DELAY)) u_dp (
    .clk          (clk),
    .rstN         (rstStbyN),
    .stb          (stb),
    .faultLatched (faultLatched),
    .faultRail    (faultRail),
    .pgDone       (pgDone)
  );

endmodule

// File: rtl/rail_sup_checker.sv
module rail_sup_checker
  import rail_sup_pkg::*;
(
  input logic                 clk,
  input logic                 rstStbyN,
  input logic [SUP_RAILS-1:0] railLow,
  input logic                 uvloStby,
  input logic                 uvlo12,
  input logic                 overTemp,
  input logic [1:0]           pwrState,
  input logic                 killOut,
  input logic                 pwrGood,
  input logic                 faultLatched,
  input logic [SUP_IDX_W-1:0] faultRail
);

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rstStbyN)
    faultLatched |=> faultLatched);

  a_r4_latch_kills: assert property (@(posedge clk) disable iff (!rstStbyN)
    faultLatched |-> killOut);

  a_r5_rail_frozen: assert property (@(posedge clk) disable iff (!rstStbyN)
    faultLatched |=> $stable(faultRail));

  a_r7_uvlo_kills: assert property (@(posedge clk) disable iff (!rstStbyN)
    (uvloStby || uvlo12) |-> killOut);

  a_r8_hot_kills: assert property (@(posedge clk) disable iff (!rstStbyN)
    overTemp |-> killOut);

  a_r9_pg_low_on_kill: assert property (@(posedge clk) disable iff (!rstStbyN)
    killOut |-> !pwrGood);

  a_r10_pg_rise_after_valid: assert property (@(posedge clk) disable iff (!rstStbyN)
    $rose(pwrGood) |-> $past(!killOut));

endmodule

bind rail_supervisor rail_sup_checker u_chk (.*);

// File: tb/rail_supervisor_test.sv
`timescale 1ns/1ps
module rail_supervisor_test;

  localparam int unsigned TRIP = 8;
  localparam int unsigned PGD  = 4;
  localparam int unsigned NVEC = 9;

  // {railLow[3:0], uvloStby, uvlo12, overTemp, pwrState[1:0], expKill, expPg}
  localparam logic [10:0] VEC [NVEC] = '{
    11'b0000_000_00_0_1,
    11'b0010_000_00_0_0,
    11'b0100_000_10_0_1,
    11'b1000_000_01_0_0,
    11'b0000_100_00_1_0,
    11'b0000_010_00_1_0,
    11'b0000_001_00_1_0,
    11'b0001_000_10_0_0,
    11'b1100_000_10_0_1
  };

  logic       clk = 1'b0;
  logic       rstStbyN = 1'b0;
  logic [3:0] railLow = '0;
  logic       uvloStby = 1'b0;
  logic       uvlo12 = 1'b0;
  logic       overTemp = 1'b0;
  logic [1:0] pwrState = 2'b00;
  logic       killOut, pwrGood, faultLatched;
  logic [1:0] faultRail;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rail_supervisor #(.TRIP_CYCLES(TRIP), .PG_DELAY(PGD)) uut (
    .clk(clk), .rstStbyN(rstStbyN), .railLow(railLow), .uvloStby(uvloStby),
    .uvlo12(uvlo12), .overTemp(overTemp), .pwrState(pwrState),
    .killOut(killOut), .pwrGood(pwrGood), .faultLatched(faultLatched),
    .faultRail(faultRail)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    railLow = '0; uvloStby = 0; uvlo12 = 0; overTemp = 0; pwrState = 2'b00;
  endtask

  task automatic doReset();
    idle();
    rstStbyN = 1'b0;
    waitN(2);
    chk("R1 reset faultLatched", faultLatched, 0);
    chk("R1 reset killOut", killOut, 0);
    rstStbyN = 1'b1;
    waitN(PGD + 2);
  endtask

  initial begin
    waitN(3);
    chk("R1 kill in reset", killOut, 0);
    chk("R1 latch in reset", faultLatched, 0);
    chk("R1 rail in reset", faultRail, 0);
    chk("R1 pgood in reset", pwrGood, 0);
    rstStbyN = 1'b1;
    waitN(PGD - 1);
    chk("R10 pgood before delay", pwrGood, 0);
    waitN(1);
    chk("R10 pgood after delay", pwrGood, 1);
    waitN(2);

    // table walk: short stimuli, never long enough to trip
    for (int v = 0; v < NVEC; v++) begin
      {railLow, uvloStby, uvlo12, overTemp, pwrState} = VEC[v][10:2];
      waitN(3);
      chk(VEC[v][1] ? "R7 table kill" : "R9 table kill", killOut, VEC[v][1]);
      chk(VEC[v][0] ? "R6 table pgood" : "R9 table pgood", pwrGood, VEC[v][0]);
      idle();
      waitN(PGD + 2);
    end
    chk("R3 no latch after table", faultLatched, 0);

    // R2 exact trip edge
    railLow = 4'b0010;
    waitN(TRIP - 1);
    chk("R2 not yet latched", faultLatched, 0);
    waitN(1);
    chk("R2 latched", faultLatched, 1);
    chk("R2 kill", killOut, 1);
    chk("R5 rail id", faultRail, 1);
    chk("R9 pgood on fault", pwrGood, 0);

    // R4 sticky
    railLow = '0; pwrState = 2'b10;
    waitN(20);
    chk("R4 still latched", faultLatched, 1);
    chk("R4 still killed", killOut, 1);
    doReset();
    chk("R4 cleared by reset", faultLatched, 0);

    // R3 dips one short, count restarts
    railLow = 4'b0001; waitN(TRIP - 1);
    railLow = '0;      waitN(1);
    railLow = 4'b0001; waitN(TRIP - 1);
    railLow = '0;      waitN(1);
    chk("R3 dips no latch", faultLatched, 0);
    chk("R3 dips no kill", killOut, 0);
    waitN(PGD + 2);

    // R5 simultaneous: lowest index wins
    railLow = 4'b1100;
    waitN(TRIP);
    chk("R5 simultaneous latched", faultLatched, 1);
    chk("R5 simultaneous rail", faultRail, 2);
    doReset();

    // R5 staggered: earlier rail kept
    railLow = 4'b1000; waitN(2);
    railLow = 4'b1001; waitN(TRIP - 2);
    chk("R5 staggered latched", faultLatched, 1);
    chk("R5 staggered rail", faultRail, 3);
    waitN(5);
    chk("R5 rail unchanged", faultRail, 3);
    doReset();

    // R6 memory mask in deep sleep
    pwrState = 2'b10; railLow = 4'b1100;
    waitN(20);
    chk("R6 masked no latch", faultLatched, 0);
    chk("R6 masked pgood", pwrGood, 1);
    pwrState = 2'b00;
    waitN(TRIP - 1);
    chk("R6 fresh count", faultLatched, 0);
    waitN(1);
    chk("R6 trips after unmask", faultLatched, 1);
    chk("R6 rail", faultRail, 2);
    doReset();

    // R7 lockout, non-latching
    railLow = 4'b0001; uvlo12 = 1'b1;
    waitN(1);
    chk("R7 kill on uvlo12", killOut, 1);
    waitN(19);
    chk("R7 no latch", faultLatched, 0);
    chk("R9 pgood in lockout", pwrGood, 0);
    railLow = '0; uvlo12 = 1'b0;
    waitN(1);
    chk("R7 released", killOut, 0);
    waitN(PGD - 2);
    chk("R10 pgood waits", pwrGood, 0);
    waitN(1);
    chk("R10 pgood returns", pwrGood, 1);

    // R8 over-temperature
    overTemp = 1'b1;
    waitN(1);
    chk("R8 kill on hot", killOut, 1);
    chk("R9 pgood hot", pwrGood, 0);
    waitN(10);
    chk("R8 no latch", faultLatched, 0);
    overTemp = 1'b0;
    waitN(1);
    chk("R8 released", killOut, 0);
    waitN(PGD + 2);

    // R11 counting suspended by standby lockout
    railLow = 4'b0010; uvloStby = 1'b1;
    waitN(20);
    chk("R11 no latch in lockout", faultLatched, 0);
    uvloStby = 1'b0;
    waitN(TRIP - 1);
    chk("R11 fresh count", faultLatched, 0);
    waitN(1);
    chk("R11 trips after lockout", faultLatched, 1);
    chk("R11 rail", faultRail, 1);
    doReset();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule